// File: doc/BRIEF.md
# Masked CAM Match Engine with Status

This block holds a small array of words and looks up a key against all of them in a single cycle. Every word carries a two-bit validity tag. A per-bit mask can leave any key bit out of the comparison. A lookup runs in one of two ways:

- An automatic lookup considers only words tagged valid.
- A forced lookup considers only words whose tag equals a tag value supplied with the request.

The engine keeps three results and packs them into a fixed 32-bit status word with active-low flags:

- whether any word hit;
- whether more than one word hit;
- the index of the lowest-numbered hit.

It also tracks which words are empty. From that it produces a next-free index and an active-low full flag.

Words are loaded through an indexed data write port, and tags are set through a separate indexed tag port. An indexed read port returns a word, and the tag of the word last read is shown in the status word. Lookup requests arrive on a valid/ready handshake. The engine drops ready in any cycle in which the data write port or the tag port is active, so a lookup never sees a half-updated array. A requester holds the request and its fields stable until it sees ready high on a clock edge.

Top module: `cam_match_engine`

## Requirements
- R1: After reset, `status` reads 0xF000001F, `next_free` reads 0, `rd_data` reads 0, and every word's tag is empty.
- R2: A mask bit of 0 includes the matching key bit in the comparison. A mask bit of 1 excludes it, so that bit position matches whatever the word holds.
- R3: A lookup with `cmp_forced`=0 can hit only words tagged valid. Tag encoding: 00 valid, 01 empty, 10 skip, 11 random.
- R4: A lookup with `cmp_forced`=1 can hit only words whose tag equals `cmp_tag`, and this holds for any of the four tag values.
- R5: Status bit 0 is low after a lookup in which at least one word hit. Status bits 4:1 hold the lowest hit index. After a lookup with no hit, bit 0 is high and bits 4:1 read 1111.
- R6: Status bit 30 is low exactly when the last accepted lookup hit two or more words.
- R7: `next_free` is the lowest index whose tag is empty, or 0 when no word is empty. Status bit 31 is low exactly when no word is empty. Both take the new tags into account at the same clock edge that writes a tag.
- R8: A read returns the word's data on `rd_data` one clock later. At the same edge, status bits 29:28 take that word's tag: bit 29 is tag bit 1 (skip), bit 28 is tag bit 0 (empty). Both bits read 11 from reset until the first read.
- R9: `cmp_ready` is low in any cycle in which `wr_en` or `tag_en` is high, and high otherwise. A request that is not accepted leaves the lookup result fields unchanged.
- R10: Status bits 27:5 always read 0.
- R11: The lookup result fields (bits 30, 4:1 and 0) change only at a clock edge that accepts a request. They compare against the array contents as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write word data |
| wr_idx | input | 4 | Index of word to write |
| wr_data | input | 64 | Data to write |
| tag_en | input | 1 | Write a word's validity tag |
| tag_idx | input | 4 | Index of tag to write |
| tag_val | input | 2 | New tag (00 valid, 01 empty, 10 skip, 11 random) |
| rd_en | input | 1 | Read a word |
| rd_idx | input | 4 | Index of word to read |
| rd_data | output | 64 | Data of the last word read |
| cmp_valid | input | 1 | Lookup request present |
| cmp_ready | output | 1 | Lookup request accepted this cycle when high |
| cmp_key | input | 64 | Lookup key |
| cmp_mask | input | 64 | Per-bit exclusion mask, 1 = ignore bit |
| cmp_forced | input | 1 | 1 = match on `cmp_tag`, 0 = valid words only |
| cmp_tag | input | 2 | Tag required by a forced lookup |
| status | output | 32 | Packed flags, read tag and hit index |
| next_free | output | 4 | Lowest empty word index |

## Verification
The hardest situations to reach from the ports are a multiple hit found only because the mask excludes the differing bits, and a forced lookup on skip or random tags while other words with equal data sit in a different tag state. The stimulus draws word data and keys from four fixed patterns, so that equal words are common. Masks are all-zero half the time and random otherwise, and tags are spread over all four codes. Directed steps also fill every tag to reach the full state, and they collide a lookup with a tag write to exercise back-pressure.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    TAG_VALID  = 2'b00,
    TAG_EMPTY  = 2'b01,
    TAG_SKIP   = 2'b10,
    TAG_RANDOM = 2'b11
  } cam_tag_e;

  localparam int STAT_W     = 32;
  localparam int BIT_FULL   = 31;
  localparam int BIT_MULTI  = 30;
  localparam int BIT_RSKIP  = 29;
  localparam int BIT_REMPTY = 28;
  localparam int BIT_HIT    = 0;
  localparam int ADDR_LSB   = 1;

endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic          several,
  output logic [IW-1:0] idx
);

  logic [N-1:0] below;

  // Lowest set index wins; scan from the top so the lowest overrides.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign below   = req - N'(1);
  assign any     = |req;
  assign several = |(req & below);

endmodule

// File: rtl/cam_store.sv
module cam_store
  import cam_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int WIDTH = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_idx,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         tag_en,
  input  logic [AW-1:0]                tag_idx,
  input  logic [1:0]                   tag_val,
  input  logic                         rd_en,
  input  logic [AW-1:0]                rd_idx,
  output logic [WORDS-1:0][WIDTH-1:0]  words_o,
  output logic [WORDS-1:0][1:0]        tags_o,
  output logic [WORDS-1:0][1:0]        tags_nxt_o,
  output logic [WIDTH-1:0]             rd_data_o,
  output logic [1:0]                   rd_tag_o
);

  logic [WORDS-1:0][WIDTH-1:0] words_q;
  logic [WORDS-1:0][1:0]       tags_q;
  logic [WIDTH-1:0]            rd_data_q;
  logic [1:0]                  rd_tag_q;

  always_comb begin
    tags_nxt_o = tags_q;
    if (tag_en) tags_nxt_o[tag_idx] = tag_val;
  end

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          words_q[g] <= '0;
          tags_q[g]  <= TAG_EMPTY;
        end else begin
          if (wr_en && wr_idx == AW'(g)) words_q[g] <= wr_data;
          tags_q[g] <= tags_nxt_o[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      rd_tag_q  <= 2'b11;
    end else if (rd_en) begin
      rd_data_q <= words_q[rd_idx];
      rd_tag_q  <= tags_q[rd_idx];
    end
  end

  assign words_o   = words_q;
  assign tags_o    = tags_q;
  assign rd_data_o = rd_data_q;
  assign rd_tag_o  = rd_tag_q;

  AST_TAG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    tag_en |=> tags_q[$past(tag_idx)] == $past(tag_val)); // R7

  AST_READ_TAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_tag_q)); // R8

endmodule

// File: rtl/cam_compare.sv
module cam_compare
  import cam_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int WIDTH = 64
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words,
  input  logic [WORDS-1:0][1:0]       tags,
  input  logic [WIDTH-1:0]            key,
  input  logic [WIDTH-1:0]            mask,
  input  logic                        forced,
  input  logic [1:0]                  req_tag,
  output logic [WORDS-1:0]            hits
);

  logic [1:0] want_tag;
  assign want_tag = forced ? req_tag : TAG_VALID;

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_lane
      logic [WIDTH-1:0] diff;
      logic             data_eq;
      logic             tag_ok;
      assign diff    = (words[g] ^ key) & ~mask;
      assign data_eq = (diff == '0);
      assign tag_ok  = (tags[g] == want_tag);
      assign hits[g] = data_eq && tag_ok;
    end
  endgenerate

endmodule

// File: rtl/cam_match_engine.sv
module cam_match_engine
  import cam_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int WIDTH = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             tag_en,
  input  logic [AW-1:0]    tag_idx,
  input  logic [1:0]       tag_val,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data,
  input  logic             cmp_valid,
  output logic             cmp_ready,
  input  logic [WIDTH-1:0] cmp_key,
  input  logic [WIDTH-1:0] cmp_mask,
  input  logic             cmp_forced,
  input  logic [1:0]       cmp_tag,
  output logic [31:0]      status,
  output logic [AW-1:0]    next_free
);

  logic [WORDS-1:0][WIDTH-1:0] words;
  logic [WORDS-1:0][1:0]       tags;
  logic [WORDS-1:0][1:0]       tags_nxt;
  logic [1:0]                  rd_tag;
  logic [WORDS-1:0]            hits;
  logic [WORDS-1:0]            empties;
  logic                        hit_any, hit_many, empty_any, empty_many;
  logic [AW-1:0]               hit_idx, empty_idx;
  logic                        accept;

  logic          hit_n_q, multi_n_q, full_n_q;
  logic [AW-1:0] addr_q, free_q;

  cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .tag_en(tag_en), .tag_idx(tag_idx), .tag_val(tag_val),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .words_o(words), .tags_o(tags), .tags_nxt_o(tags_nxt),
    .rd_data_o(rd_data), .rd_tag_o(rd_tag)
  );

  cam_compare #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cmp (
    .words(words), .tags(tags), .key(cmp_key), .mask(cmp_mask),
    .forced(cmp_forced), .req_tag(cmp_tag), .hits(hits)
  );

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_empty
      assign empties[g] = (tags_nxt[g] == TAG_EMPTY);
    end
  endgenerate

  cam_prio_enc #(.N(WORDS)) u_hit_pe (
    .req(hits), .any(hit_any), .several(hit_many), .idx(hit_idx)
  );

  cam_prio_enc #(.N(WORDS)) u_free_pe (
    .req(empties), .any(empty_any), .several(empty_many), .idx(empty_idx)
  );

  // Array updates and lookups are serialized: writers take priority.
  assign cmp_ready = !(wr_en || tag_en);
  assign accept    = cmp_valid && cmp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_n_q   <= 1'b1;
      multi_n_q <= 1'b1;
      addr_q    <= '1;
    end else if (accept) begin
      hit_n_q   <= !hit_any;
      multi_n_q <= !hit_many;
      addr_q    <= hit_any ? hit_idx : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_n_q <= 1'b1;
      free_q   <= '0;
    end else begin
      full_n_q <= empty_any;
      free_q   <= empty_any ? empty_idx : '0;
    end
  end

  always_comb begin
    status                       = '0;
    status[BIT_FULL]             = full_n_q;
    status[BIT_MULTI]            = multi_n_q;
    status[BIT_RSKIP]            = rd_tag[1];
    status[BIT_REMPTY]           = rd_tag[0];
    status[ADDR_LSB +: AW]       = addr_q;
    status[BIT_HIT]              = hit_n_q;
  end

  assign next_free = free_q;

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !status[BIT_MULTI] |-> !status[BIT_HIT]); // R6

  AST_MISS_ADDR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    status[BIT_HIT] |-> (status[ADDR_LSB +: AW] == '1)); // R5

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_valid && cmp_ready) |=> $stable(status[BIT_MULTI]) && $stable(status[ADDR_LSB +: AW])
      && $stable(status[BIT_HIT])); // R11

  AST_FULL_FREE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !status[BIT_FULL] |-> (next_free == '0)); // R7

  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || tag_en) |-> !cmp_ready); // R9

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[27:ADDR_LSB+AW] == '0); // R10

endmodule

// File: tb/tb_cam_match_engine.sv
module tb_cam_match_engine;

  localparam int W = 16;
  localparam int D = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 0, tag_en = 0, rd_en = 0, cmp_valid = 0, cmp_forced = 0;
  logic [3:0]    wr_idx = 0, tag_idx = 0, rd_idx = 0;
  logic [D-1:0]  wr_data = 0, cmp_key = 0, cmp_mask = 0;
  logic [1:0]    tag_val = 0, cmp_tag = 0;
  logic [D-1:0]  rd_data;
  logic          cmp_ready;
  logic [31:0]   status;
  logic [3:0]    next_free;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [D-1:0] m_mem [W];
  logic [1:0]   m_tag [W];
  logic [D-1:0] m_rd;
  logic [1:0]   m_rtag;
  logic         m_hit_n, m_multi_n;
  logic [3:0]   m_addr;

  always #2.5 clk = ~clk;

  cam_match_engine dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .tag_en(tag_en), .tag_idx(tag_idx), .tag_val(tag_val),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_key(cmp_key),
    .cmp_mask(cmp_mask), .cmp_forced(cmp_forced), .cmp_tag(cmp_tag),
    .status(status), .next_free(next_free)
  );

  task automatic chk(string req, string ctx, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual %h expected %h", req, ctx, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_free();
    for (int i = 0; i < W; i++) if (m_tag[i] == 2'b01) return 4'(i);
    return 4'd0;
  endfunction

  function automatic logic exp_full_n();
    for (int i = 0; i < W; i++) if (m_tag[i] == 2'b01) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[31] = exp_full_n();
    s[30] = m_multi_n;
    s[29:28] = m_rtag;
    s[4:1] = m_addr;
    s[0] = m_hit_n;
    return s;
  endfunction

  task automatic model_compare(logic [D-1:0] key, logic [D-1:0] mask, logic forced, logic [1:0] t);
    int n = 0;
    logic [3:0] first = 4'hF;
    for (int i = W - 1; i >= 0; i--) begin
      logic [1:0] want = forced ? t : 2'b00;
      if ((((m_mem[i] ^ key) & ~mask) == '0) && m_tag[i] == want) begin
        n++;
        first = 4'(i);
      end
    end
    m_hit_n = (n == 0);
    m_multi_n = (n < 2);
    m_addr = (n == 0) ? 4'hF : first;
  endtask

  task automatic step(string ctx,
                      logic we, logic [3:0] wi, logic [D-1:0] wd,
                      logic te, logic [3:0] ti, logic [1:0] tv,
                      logic re, logic [3:0] ri,
                      logic cv, logic [D-1:0] key, logic [D-1:0] mask,
                      logic forced, logic [1:0] ct);
    logic [31:0] es;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    tag_en = te; tag_idx = ti; tag_val = tv;
    rd_en = re; rd_idx = ri;
    cmp_valid = cv; cmp_key = key; cmp_mask = mask; cmp_forced = forced; cmp_tag = ct;
    #1;
    chk("R9", ctx, 64'(cmp_ready), 64'(!(we || te)));
    @(posedge clk);
    if (cv && !(we || te)) model_compare(key, mask, forced, ct);
    if (re) begin m_rd = m_mem[ri]; m_rtag = m_tag[ri]; end
    if (we) m_mem[wi] = wd;
    if (te) m_tag[ti] = tv;
    #2;
    wr_en = 0; tag_en = 0; rd_en = 0; cmp_valid = 0;
    es = exp_status();
    chk("R5", ctx, 64'({status[4:1], status[0]}), 64'({es[4:1], es[0]}));
    chk("R6", ctx, 64'(status[30]), 64'(es[30]));
    chk("R7", ctx, 64'({status[31], next_free}), 64'({es[31], exp_free()}));
    chk("R8", ctx, 64'(status[29:28]), 64'(es[29:28]));
    chk("R10", ctx, 64'(status[27:5]), 64'd0);
    if (re) chk("R8", ctx, rd_data, m_rd);
  endtask

  task automatic put(logic [3:0] i, logic [D-1:0] d, logic [1:0] t);
    step("load", 1, i, d, 1, i, t, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(string ctx, logic [D-1:0] key, logic [D-1:0] mask, logic forced, logic [1:0] t);
    step(ctx, 0, 0, 0, 0, 0, 0, 0, 0, 1, key, mask, forced, t);
  endtask

  function automatic logic [D-1:0] pat(int k);
    case (k)
      0: return 64'hA5A5_0000_FFFF_1234;
      1: return 64'hA5A5_0000_FFFF_1235;
      2: return 64'h0F0F_F0F0_0000_8000;
      default: return 64'h8000_0000_0000_0001;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < W; i++) begin m_mem[i] = '0; m_tag[i] = 2'b01; end
    m_rd = '0; m_rtag = 2'b11; m_hit_n = 1; m_multi_n = 1; m_addr = 4'hF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset status", 64'(status), 64'h0000_0000_F000_001F);
    chk("R1", "reset next_free", 64'(next_free), 64'd0);
    chk("R1", "reset rd_data", rd_data, 64'd0);

    // R7: loading advances the next-free index
    put(0, pat(0), 2'b00);
    put(1, pat(0), 2'b00);
    put(2, pat(2), 2'b00);
    chk("R7", "three loaded", 64'(next_free), 64'd3);

    // R5 R6: multiple exact hit, lowest index
    look("R6 double hit", pat(0), 0, 0, 0);
    chk("R5", "double hit addr", 64'(status[4:1]), 64'd0);
    look("R5 single hit", pat(2), 0, 0, 0);
    chk("R5", "single hit addr", 64'(status[4:1]), 64'd2);
    look("R5 miss", pat(3), 0, 0, 0);
    // R2: mask bit 1 excludes, mask 0 includes
    look("R2 masked lsb", pat(1), 64'h1, 0, 0);
    chk("R2", "masked lsb hit", 64'(status[0]), 64'd0);
    look("R2 unmasked lsb", pat(1), 64'h2, 0, 0);
    chk("R2", "unmasked lsb miss", 64'(status[0]), 64'd1);

    // R3 R4: forced and automatic compares respect tags
    step("R4 retag skip", 0, 0, 0, 1, 1, 2'b10, 0, 0, 0, 0, 0, 0, 0);
    look("R4 forced skip", pat(0), 0, 1, 2'b10);
    chk("R4", "forced skip addr", 64'(status[4:1]), 64'd1);
    look("R3 auto after skip", pat(0), 0, 0, 0);
    chk("R3", "auto single", 64'(status[30]), 64'd1);
    look("R4 forced empty", 64'd0, 0, 1, 2'b01);
    chk("R4", "forced empty addr", 64'(status[4:1]), 64'd3);

    // R8: read shows data and tag
    step("R8 read", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    chk("R8", "read skip tag", 64'(status[29:28]), 64'd2);

    // R9 R11: collision with tag write blocks the lookup
    step("R11 blocked", 0, 0, 0, 1, 5, 2'b11, 0, 0, 1, pat(2), 0, 0, 0);

    // R7: full array
    for (int i = 0; i < W; i++) put(4'(i), pat(i % 4), 2'b00);
    chk("R7", "full flag", 64'(status[31]), 64'd0);
    step("R7 free one", 0, 0, 0, 1, 9, 2'b01, 0, 0, 0, 0, 0, 0, 0);
    chk("R7", "freed index", 64'(next_free), 64'd9);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [D-1:0] m;
      m = ($urandom % 2 == 0) ? 64'd0 : {$urandom, $urandom};
      step("random",
           ($urandom % 5 == 0), 4'($urandom), pat($urandom % 4),
           ($urandom % 4 == 0), 4'($urandom), 2'($urandom),
           ($urandom % 4 == 0), 4'($urandom),
           ($urandom % 2 == 0), pat($urandom % 4), m,
           1'($urandom), 2'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule